// File: doc/BRIEF.md
# Serial Ones-Complement Sequencer

This block holds a word in a shift register and inverts it in place one bit per work step. Each work step rotates the word one place toward its least significant end. The bit that falls off that end is inverted and re-enters at the most significant end. After as many work steps as the word has bits, every bit has passed through the inverter once, and the register holds the ones' complement of the word it was loaded with.

A one-hot step register runs the sequence. A work step is always followed by a test step. The test step compares the step counter with the word width. It either sends control back to the work step or moves it on to a done step. The done step raises a completion flag. The done step and the flag then stay put until the next accepted start. The word, the counter, the step register and the flag are all visible at the ports.

A word is written through a parallel load port while the sequencer is idle or done. A single-cycle start pulse then begins a run. Start and load pulses that arrive during a run are dropped.

Top module: `serial_complementer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the word, counter, step register and done flag all clear to zero on that edge, whatever the other inputs are.
- R2: When `load_i` is high at an edge while the sequencer is idle (`step_o` = 000) or done (`step_o` = 100), `word_o` takes `load_data_i` after that edge. During a run (`step_o` bit 0 or bit 1 set), `load_i` has no effect on `word_o`.
- R3: A `start_i` pulse seen at an edge while idle or done leaves `count_o` = 0, `fini_o` = 0 and `step_o` = 001 (the work step) after that edge.
- R4: An edge taken in the work step (`step_o` = 001) does three things: it shifts the word right by one place with the inverted old bit 0 entering bit W-1, it increments `count_o`, and it moves `step_o` to 010 (the test step).
- R5: An edge taken in the test step moves `step_o` to 100 (done) when `count_o` equals W, and otherwise back to 001.
- R6: `fini_o` rises on the edge after the done step is entered. It then stays high, and `step_o` stays 100, until the next accepted start.
- R7: When `fini_o` rises, `word_o` equals the bitwise inverse of the loaded word. For W = 4: 1111 becomes 0111, 0011, 0001 and then 0000, and 0101 ends as 1010.
- R8: `fini_o` first reads high 2W+1 edges after the edge that accepted the start. With the default W = 4 this is 9 edges.
- R9: A `start_i` pulse during a run has no effect. The run continues with the same step order, count and latency.
- R10: `step_o` never has more than one bit set.
- R11: `count_o` is clog2(W+1) bits wide, which is 3 bits for W = 4. It never exceeds W. Its value is W when the done step is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-cycle request to begin a run |
| load_i | input | 1 | Parallel write strobe for the word |
| load_data_i | input | W | Word to be written |
| word_o | output | W | Current contents of the shift register |
| count_o | output | CW | Number of work steps taken in this run |
| step_o | output | 3 | One-hot step: bit 0 work, bit 1 test, bit 2 done |
| fini_o | output | 1 | Completion flag |

## Verification
The assertions assume that `load_i` and `start_i` are synchronous single-cycle pulses. They also assume that a start accepted from idle or done may share an edge with a load. The stimulus drives these pulses for exactly one cycle, away from the clock edge, and starts every run from a loaded idle or done state. It sweeps all sixteen 4-bit words. In one run it deliberately fires a start and a load in the middle of the run, so that the requirement to ignore them is exercised without breaking the pulse assumption.

// File: rtl/sercomp_pkg.sv
// Package: shared step encoding for the serial complementer.
// Assumes three one-hot steps; the all-zero value means idle after reset.
package sercomp_pkg;
    typedef enum logic [2:0] {
        STEP_IDLE = 3'b000,
        STEP_WORK = 3'b001,
        STEP_TEST = 3'b010,
        STEP_DONE = 3'b100
    } step_t;
endpackage

// File: rtl/sercomp_word.sv
// Word register: parallel load, or rotate right with the outgoing bit
// inverted. Assumes load and shift are never requested in the same cycle.
module sercomp_word #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] word_q
);
    // Hold, load or complement-rotate the word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (shift_en)
            word_q <= {~word_q[0], word_q[W-1:1]};
        else if (load_en)
            word_q <= load_data;
    end

    assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_q[W-1] == ~$past(word_q[0])) &&
                     (word_q[W-2:0] == $past(word_q[W-1:1])));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(word_q));
endmodule

// File: rtl/sercomp_counter.sv
// Step counter: cleared by an accepted start, incremented per work step.
// Assumes at most W work steps per run; flags the value W for the test step.
module sercomp_counter #(
    parameter int W  = 4,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          incr,
    output logic [CW-1:0] cnt_q,
    output logic          at_last
);
    localparam logic [CW-1:0] LAST = CW'(W);

    // Count work steps since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (incr)
            cnt_q <= cnt_q + 1'b1;
    end

    // Decode the completion value.
    always_comb at_last = (cnt_q == LAST);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/sercomp_seq.sv
// One-hot sequencer with the done flag. Work always hands over to test;
// test returns to work or moves to done; done holds until a start.
// Assumes start_acc is already qualified by the top (idle or done only).
module sercomp_seq
    import sercomp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_acc,
    input  logic  at_last,
    output step_t step_q,
    output logic  fini_q
);
    step_t step_d;

    // Next-step selection.
    always_comb begin
        step_d = step_q;
        if (start_acc)
            step_d = STEP_WORK;
        else begin
            case (step_q)
                STEP_WORK: step_d = STEP_TEST;
                STEP_TEST: step_d = at_last ? STEP_DONE : STEP_WORK;
                default:   step_d = step_q;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= STEP_IDLE;
        else        step_q <= step_d;
    end

    // Done flag: cleared on start, set while in the done step.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) fini_q <= 1'b0;
        else if (step_q == STEP_DONE) fini_q <= 1'b1;
    end

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_q));

    assert_test_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == STEP_TEST && !start_acc) |=>
            (step_q == ($past(at_last) ? STEP_DONE : STEP_WORK)));

    assert_fini_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == STEP_DONE && !start_acc) |=> fini_q);
endmodule

// File: rtl/serial_complementer.sv
// Top: serial ones-complement sequencer. Qualifies start and load so that
// both act only while idle or done, and wires datapath, counter and
// sequencer together. Assumes start_i and load_i are synchronous pulses.
module serial_complementer
    import sercomp_pkg::*;
#(
    parameter  int W  = 4,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          load_i,
    input  logic [W-1:0]  load_data_i,
    output logic [W-1:0]  word_o,
    output logic [CW-1:0] count_o,
    output logic [2:0]    step_o,
    output logic          fini_o
);
    step_t step_q;
    logic  running;
    logic  start_acc;
    logic  load_acc;
    logic  work;
    logic  at_last;

    // Qualify edge requests against the running state.
    always_comb begin
        work      = (step_q == STEP_WORK);
        running   = work || (step_q == STEP_TEST);
        start_acc = start_i && !running;
        load_acc  = load_i && !running;
    end

    sercomp_word #(.W(W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (work),
        .load_en   (load_acc),
        .load_data (load_data_i),
        .word_q    (word_o)
    );

    sercomp_counter #(.W(W), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_acc),
        .incr    (work),
        .cnt_q   (count_o),
        .at_last (at_last)
    );

    sercomp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .at_last   (at_last),
        .step_q    (step_q),
        .fini_q    (fini_o)
    );

    // Expose the step register.
    always_comb step_o = step_q;

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 3'b001 && start_i) |=> (step_o == 3'b010));

    assert_fini_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fini_o && !start_i) |=> fini_o);

    assert_load_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 3'b010 && load_i) |=> $stable(word_o));

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (step_o == 3'b000 || step_o == 3'b100)) |=>
            (step_o == 3'b001 && !fini_o));
endmodule

// File: tb/serial_complementer_tb_top.sv
module serial_complementer_tb_top;
    localparam int W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       load_i = 1'b0;
    logic [3:0] load_data_i = '0;
    logic [3:0] word_o;
    logic [2:0] count_o;
    logic [2:0] step_o;
    logic       fini_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    serial_complementer #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
        .load_data_i(load_data_i), .word_o(word_o), .count_o(count_o),
        .step_o(step_o), .fini_o(fini_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset dominates a load and a start
        load_i = 1'b1; load_data_i = 4'hF; start_i = 1'b1;
        repeat (3) tick();
        chk("R1 word", word_o, 0);
        chk("R1 count", count_o, 0);
        chk("R1 step", step_o, 0);
        chk("R1 fini", fini_o, 0);
        load_i = 1'b0; start_i = 1'b0; rst_n = 1'b1;
        tick();

        for (int v = 0; v < 16; v++) begin
            int n;
            int first;
            int inv;
            first = ((v >> 1) | (((~v) & 1) << 3)) & 15;
            inv   = (~v) & 15;

            load_i = 1'b1; load_data_i = 4'(v);
            tick();
            load_i = 1'b0;
            chk("R2 load when idle/done", word_o, v);

            start_i = 1'b1;
            tick();
            start_i = 1'b0;
            chk("R3 step after start", step_o, 1);
            chk("R3 count after start", count_o, 0);
            chk("R3 fini after start", fini_o, 0);

            n = 0;
            while (!fini_o && n < 30) begin
                if (v == 5 && n == 3) begin
                    start_i = 1'b1; load_i = 1'b1; load_data_i = 4'h0;
                end
                tick();
                start_i = 1'b0; load_i = 1'b0;
                n++;
                chk("R10 step onehot0", ((step_o & (step_o - 3'd1)) == 0) ? 1 : 0, 1);
                if (n == 1) begin
                    chk("R4 word after first work", word_o, first);
                    chk("R4 count after first work", count_o, 1);
                    chk("R4 step after first work", step_o, 2);
                end
                if (n == 2) chk("R5 test returns to work", step_o, 1);
                if (n == 8) chk("R5 test enters done", step_o, 4);
                if (v == 5 && n == 4) chk("R9 start mid-run ignored", step_o, 1);
            end
            chk("R8 edges to fini", n, 2 * W + 1);
            chk("R7 ones complement", word_o, inv);
            chk("R11 count at done", count_o, W);
            chk("R6 step at done", step_o, 4);

            repeat (3) tick();
            chk("R6 fini holds", fini_o, 1);
            chk("R6 step holds", step_o, 4);
            chk("R7 word stable after done", word_o, inv);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule